// File: doc/BRIEF.md
# Gray-Code Scanned Probe Selector

This block observes one of many internal probe signals at a time through a balanced binary tree of 2:1 multiplexers. A host places a start index in the address register and then advances it one position per serial clock. The selected probe bit goes to a single output, which feeds a serial port. The address counts in Gray code, so each advance flips exactly one tree level's select line. Because only one select net switches per step, switching power stays low and the control fanout is spread over the tree levels instead of sitting on one large network.

Each tree level receives its own copy of its select bit. That copy is delayed by the number of pipeline registers placed ahead of the level. As a result, the data and the select of any one address stay aligned as they pass down through the tree. An optional register after every `PIPE_EVERY` levels shortens the combinational depth. The output valid flag and the address tag are delayed by the same amount as the data.

Top module: `probe_scan_tree`

## Requirements
- R1: While reset is asserted and on release, `bit_o`, `valid_o` and `addr_o` are 0.
- R2: When `load_i` is high at a clock edge, the address register takes the Gray code of `start_idx_i` (g = b xor (b >> 1)). `load_i` takes priority over `step_i`.
- R3: When `step_i` is high and `load_i` is low, the address moves to the Gray code of its binary index plus one. The new address differs from the old one in exactly one bit.
- R4: When neither `load_i` nor `step_i` is high, the address register keeps its value.
- R5: `bit_o` equals `probe_i[a]`, where `a` is the Gray address read as a plain binary probe index. `addr_o` carries `a` in the same cycle. Both appear LAT = 2 + floor((log2(N_PROBES)-1)/PIPE_EVERY) clock edges after the address register was written. LAT = 2 when `PIPE_EVERY` is 0, and LAT = 4 for the defaults of 128 probes with a register every 3 levels.
- R6: Starting from any start index, N_PROBES steps visit every probe index exactly once. The address after the last step equals the start address.
- R7: `valid_o` stays low from reset until LAT edges after the first load, even if steps occur before that load. Once high, it stays high until the next reset.
- R8: Stepping from binary index N_PROBES-1 (Gray address with only the top bit set) wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| probe_i | input | N_PROBES | Observed internal signals |
| load_i | input | 1 | Load the start index into the address register |
| step_i | input | 1 | Advance the address by one Gray step |
| start_idx_i | input | log2(N_PROBES) | Binary start index |
| bit_o | output | 1 | Selected probe bit |
| valid_o | output | 1 | `bit_o` and `addr_o` belong to a loaded address |
| addr_o | output | log2(N_PROBES) | Gray address matching `bit_o` |

## Verification
The hardest case to reach from the ports is the wrap through the top of the index range inside a long scan, combined with loads arriving while the pipeline still holds earlier addresses. The stimulus covers this in three ways. It runs full N_PROBES-step scans from several start indices, including N_PROBES-1. It issues a load together with a step. It inserts idle cycles between steps. A scoreboard queue, keyed by the cycle each result is due, follows the in-flight addresses past the pipeline latency and checks that each one comes out matched to its own probe bit.

// File: rtl/probe_scan_pkg.sv
package probe_scan_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } ctr_op_e;

  // registers between address register and output, inclusive of both ends
  function automatic int unsigned scan_latency(input int unsigned levels,
                                               input int unsigned every);
    if (every == 0) return 2;
    return 2 + (levels - 1) / every;
  endfunction
endpackage

// File: rtl/gray_step_ctr.sv
module gray_step_ctr
  import probe_scan_pkg::*;
#(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] start_i,
  output logic [W-1:0] gray_o
);
  logic [W-1:0] gray_q, gray_d, bin_cur, bin_nxt;
  ctr_op_e op;

  always_comb begin
    bin_cur[W-1] = gray_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin_cur[i] = bin_cur[i+1] ^ gray_q[i];
  end

  assign bin_nxt = bin_cur + 1'b1;

  always_comb begin
    if (load_i)      op = OP_LOAD;
    else if (step_i) op = OP_STEP;
    else             op = OP_HOLD;
  end

  always_comb begin
    unique case (op)
      OP_LOAD: gray_d = start_i ^ (start_i >> 1);
      OP_STEP: gray_d = bin_nxt ^ (bin_nxt >> 1);
      default: gray_d = gray_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gray_q <= '0;
    else         gray_q <= gray_d;
  end

  assign gray_o = gray_q;

  // R3
  single_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> ($countones(gray_q ^ $past(gray_q)) == 1));
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(gray_q));
  // R2
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (gray_q == ($past(start_i) ^ ($past(start_i) >> 1))));
endmodule

// File: rtl/sel_skew_line.sv
module sel_skew_line #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] sh_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) sh_q[i] <= '0;
      end else begin
        sh_q[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) sh_q[i] <= sh_q[i-1];
      end
    end
    assign q_o = sh_q[DEPTH-1];
  end
endmodule

// File: rtl/mux_stage.sv
module mux_stage #(
  parameter int unsigned W_IN = 2,
  parameter bit          REGD = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [W_IN-1:0]   d_i,
  output logic [W_IN/2-1:0] q_o
);
  localparam int unsigned W_OUT = W_IN / 2;
  logic [W_OUT-1:0] pick;

  for (genvar i = 0; i < W_OUT; i++) begin : g_pair
    assign pick[i] = sel_i ? d_i[2*i+1] : d_i[2*i];
  end

  if (REGD) begin : g_reg
    logic [W_OUT-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= pick;
    end
    assign q_o = q_q;
  end else begin : g_comb
    assign q_o = pick;
  end
endmodule

// File: rtl/probe_scan_tree.sv
module probe_scan_tree
  import probe_scan_pkg::*;
#(
  parameter int unsigned N_PROBES   = 128,
  parameter int unsigned PIPE_EVERY = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PROBES-1:0]         probe_i,
  input  logic                        load_i,
  input  logic                        step_i,
  input  logic [$clog2(N_PROBES)-1:0] start_idx_i,
  output logic                        bit_o,
  output logic                        valid_o,
  output logic [$clog2(N_PROBES)-1:0] addr_o
);
  localparam int unsigned LVL = $clog2(N_PROBES);
  localparam int unsigned LAT = scan_latency(LVL, PIPE_EVERY);

  logic [LVL-1:0] gray_q, sel_q;
  logic           armed_q;

  gray_step_ctr #(.W(LVL)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .step_i  (step_i),
    .start_i (start_idx_i),
    .gray_o  (gray_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b0;
    else if (load_i) armed_q <= 1'b1;
  end

  // one launch register for all select bits
  sel_skew_line #(.W(LVL), .DEPTH(1)) u_sel_launch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gray_q),
    .q_o   (sel_q)
  );

  // tree: level l consumes address bit l, delayed by the registers above it
  for (genvar l = 0; l < LVL; l++) begin : g_lv
    localparam int unsigned W_IN = N_PROBES >> l;
    localparam int unsigned SKEW = (PIPE_EVERY == 0) ? 0 : l / PIPE_EVERY;
    localparam bit          REGD = (l == LVL - 1) ||
                                   ((PIPE_EVERY != 0) && (((l + 1) % PIPE_EVERY) == 0));
    logic [W_IN-1:0]   din;
    logic [W_IN/2-1:0] dout;
    logic              sel_l;

    if (l == 0) begin : g_first
      assign din = probe_i;
    end else begin : g_next
      assign din = g_lv[l-1].dout;
    end

    sel_skew_line #(.W(1), .DEPTH(SKEW)) u_skew (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (sel_q[l]),
      .q_o   (sel_l)
    );

    mux_stage #(.W_IN(W_IN), .REGD(REGD)) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sel_i (sel_l),
      .d_i   (din),
      .q_o   (dout)
    );
  end

  assign bit_o = g_lv[LVL-1].dout[0];

  // tag follows the data through the same number of registers
  logic [LVL:0] tag_q;
  sel_skew_line #(.W(LVL + 1), .DEPTH(LAT)) u_tag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({armed_q, gray_q}),
    .q_o   (tag_q)
  );
  assign valid_o = tag_q[LVL];
  assign addr_o  = tag_q[LVL-1:0];

  // R7
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
  // R7
  valid_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> !valid_o);
endmodule

// File: tb/tb_probe_scan_tree.sv
module tb_probe_scan_tree;
  localparam int unsigned N   = 128;
  localparam int unsigned K   = 3;
  localparam int unsigned W   = $clog2(N);
  localparam int unsigned LAT = 4; // R5: 2 + (7-1)/3

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] probe = '0;
  logic         load = 1'b0, step = 1'b0;
  logic [W-1:0] sidx = '0;
  logic         bit_o, valid_o;
  logic [W-1:0] addr_o;

  probe_scan_tree #(.N_PROBES(N), .PIPE_EVERY(K)) dut (
    .clk_i(clk), .rst_ni(rst_n), .probe_i(probe), .load_i(load), .step_i(step),
    .start_idx_i(sidx), .bit_o(bit_o), .valid_o(valid_o), .addr_o(addr_o)
  );

  always #10 clk = ~clk; // 50 MHz

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;

  typedef struct {
    int unsigned  due;
    logic [W-1:0] addr;
    bit           is_step;
    bit           in_scan;
  } item_t;
  item_t q[$];

  int unsigned  m_idx = 0;
  bit           m_armed = 0;
  bit           scanning = 0;
  int           seen[N];
  logic [W-1:0] last_addr = '0;
  bit           have_last = 0;

  function automatic logic [W-1:0] to_gray(input int unsigned b);
    logic [W-1:0] v = W'(b);
    return v ^ (v >> 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: one call per cycle
  task automatic drive(input bit ld, input bit st, input int unsigned s);
    item_t it;
    @(negedge clk);
    load = ld; step = st; sidx = W'(s);
    if (ld) begin m_idx = s % N; m_armed = 1; end       // R2 priority
    else if (st) m_idx = (m_idx + 1) % N;               // R3
    if (m_armed) begin
      it.due = cyc + 1 + LAT;
      it.addr = to_gray(m_idx);
      it.is_step = st && !ld;
      it.in_scan = scanning && it.is_step;
      q.push_back(it);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    load = 0; step = 0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() != 0 && q[0].due == cyc) begin
        it = q.pop_front();
        chk(valid_o === 1'b1, "R7", "valid", valid_o, 1);
        chk(addr_o === it.addr, "R5", "addr", addr_o, it.addr);
        chk(bit_o === probe[it.addr], "R5", "bit", bit_o, probe[it.addr]);
        if (it.is_step && have_last)
          chk($countones(addr_o ^ last_addr) == 1, "R3", "hamming",
              $countones(addr_o ^ last_addr), 1);
        else if (!it.is_step && have_last && !load)
          ; // hold or load: covered by addr compare (R2, R4)
        if (it.in_scan) seen[addr_o]++;
        last_addr = addr_o;
        have_last = 1;
      end
    end
  end

  task automatic full_scan(input int unsigned s, input logic [N-1:0] pat);
    probe = pat;
    for (int i = 0; i < N; i++) seen[i] = 0;
    drive(1, 0, s);
    scanning = 1;
    for (int i = 0; i < N; i++) drive(0, 1, 0);
    scanning = 0;
    drain();
    for (int i = 0; i < N; i++)
      if (seen[i] != 1) chk(0, "R6", "visit count", seen[i], 1);
    chk(1, "R6", "visits", 0, 0);
    chk(addr_o === to_gray(s), "R6", "returns to start", addr_o, to_gray(s));
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(bit_o === 0, "R1", "bit in reset", bit_o, 0);
    chk(valid_o === 0, "R1", "valid in reset", valid_o, 0);
    chk(addr_o === 0, "R1", "addr in reset", addr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o === 0 && addr_o === 0, "R1", "after release", valid_o, 0);
    // R7: steps before any load leave valid low
    probe = '1;
    for (int i = 0; i < LAT + 3; i++) begin
      drive(0, 1, 0);
      chk(valid_o === 0, "R7", "valid before load", valid_o, 0);
    end
    // R5, R6 with several patterns and starts
    full_scan(0,  {4{32'hA5C3_0F96}});
    full_scan(77, {32'h1357_9BDF, 32'h0246_8ACE, 32'hFFFF_0000, 32'h8001_7FFE});
    full_scan(N - 1, {64'h0, 64'hDEAD_BEEF_CAFE_F00D});
    // R8 wrap from top index
    probe = {4{32'h6C3A_95E1}};
    drive(1, 0, N - 1);
    drive(0, 1, 0);
    drain();
    chk(addr_o === 0, "R8", "wrap to zero", addr_o, 0);
    // R2 load wins over step; R4 hold across idle cycles
    drive(1, 1, 42);
    drive(0, 0, 0);
    drive(0, 0, 0);
    drive(0, 1, 0);
    drive(0, 0, 9);
    drive(1, 0, 5);
    drive(0, 1, 0);
    drain();
    chk(addr_o === to_gray(6), "R2", "final addr", addr_o, to_gray(6));
    // R4: idle with changing start index, output unchanged
    for (int i = 0; i < LAT + 2; i++) drive(0, 0, i + 3);
    drain();
    chk(addr_o === to_gray(6), "R4", "idle keeps addr", addr_o, to_gray(6));
    chk(valid_o === 1, "R7", "valid stays high", valid_o, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule